// File: doc/BRIEF.md
# Dual-Order Burst Address Sequencer

This block generates the memory address used during a four-beat burst. When its load input is asserted, it captures the whole start address. The upper part is held unchanged for the rest of the burst. The low bits become the burst start, and a 2-bit position counter is cleared. Each later clock with the active-low advance input driven low moves the counter one position, wrapping after four. The low address bits are then formed from the start and the position, using one of two orderings.

A static strap input picks the ordering. With the strap at 0, the low bits follow a linear wraparound sequence, so start 1 gives 1, 2, 3, 0. With the strap at 1, which is the default for an undriven strap, the low bits follow an interleaved sequence, so start 1 gives 1, 0, 3, 2. The block is placed beside a synchronous memory core. An external arbiter decides when an address strobe has been accepted and pulses `load_i`.

Top module: `burst_seq`

## Requirements
- R1: While `rst_n` is low and after reset, `addr_o` and `pos_o` are both zero.
- R2: A clock edge with `load_i` high makes `addr_o` equal to the `addr_i` value sampled at that edge, and sets `pos_o` to 0.
- R3: A clock edge with `load_i` low and `adv_n_i` low increments `pos_o` by one, modulo 4.
- R4: A clock edge with `load_i` low and `adv_n_i` high leaves `pos_o` and `addr_o` unchanged.
- R5: With `order_i` = 0 (linear), the low two bits of `addr_o` equal (start + `pos_o`) mod 4. `order_i` must remain constant while out of reset.
- R6: With `order_i` = 1 (interleaved), the low two bits of `addr_o` equal start XOR `pos_o`.
- R7: Bits above the low two of `addr_o` keep the captured value until the next load.
- R8: A load takes priority over an advance in the same cycle and restarts the count at 0, including in the middle of a burst.
- R9: After four advances from a load, `pos_o` is back at 0 and `addr_o` equals the loaded address again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Accepted strobe: capture `addr_i` and restart the burst |
| addr_i | input | ADDR_W (18) | Start address of the burst |
| adv_n_i | input | 1 | Active-low advance request |
| order_i | input | 1 | Static ordering strap: 0 = linear, 1 = interleaved |
| addr_o | output | ADDR_W (18) | Current burst address |
| pos_o | output | 2 | Burst position, 0 to 3 |

## Verification
Every result appears one cycle after its stimulus. The load, advance and hold inputs are sampled at a rising edge, and the registered address and position take their new values right after that edge. The order mapping adds no register stage. The driver applies inputs on the falling edge and queues the value expected after the following rising edge. The monitor pops one entry 1 ns after each rising edge, so every comparison lines up with exactly one stimulus cycle. Both orderings are run from all four start values, with holds, wraps and mid-burst reloads.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } order_e;

   // Variant selection for the order mapping
   localparam int MAP_STRAP      = 0;
   localparam int MAP_LINEAR     = 1;
   localparam int MAP_INTERLEAVE = 2;
endpackage

// File: rtl/burst_seq_ctr.sv
module burst_seq_ctr #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             adv_n_i,
   output logic [CNT_W-1:0] cnt_o
);
   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("burst_seq_ctr: CNT_W must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (load_i)   cnt_q <= '0;
      else if (!adv_n_i) cnt_q <= CNT_W'(cnt_q + 1'b1);
   end

   assign cnt_o = cnt_q;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1))); // R3
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && adv_n_i) |=> $stable(cnt_o)); // R4
   AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_o == '0)); // R8
endmodule

// File: rtl/burst_seq_areg.sv
module burst_seq_areg #(
   parameter int ADDR_W = 18,
   parameter int CNT_W  = 2,
   localparam int HI_W  = ADDR_W - CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [HI_W-1:0]   base_o,
   output logic [CNT_W-1:0]  start_o
);
   generate
      if (ADDR_W <= CNT_W) begin : g_bad_w
         $error("burst_seq_areg: ADDR_W must exceed CNT_W");
      end
   endgenerate

   logic [HI_W-1:0]  base_q;
   logic [CNT_W-1:0] start_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         start_q <= '0;
      end else if (load_i) begin
         base_q  <= addr_i[ADDR_W-1:CNT_W];
         start_q <= addr_i[CNT_W-1:0];
      end
   end

   assign base_o  = base_q;
   assign start_o = start_q;

   AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(base_o)); // R7
   AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> ({base_o, start_o} == $past(addr_i))); // R2
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
   import burst_seq_pkg::*;
#(
   parameter int CNT_W   = 2,
   parameter int MAP_SEL = MAP_STRAP
) (
   input  order_e           order_i,
   input  logic [CNT_W-1:0] start_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] low_o
);
   logic [CNT_W-1:0] lin_w;
   logic [CNT_W-1:0] ilv_w;

   assign lin_w = CNT_W'(start_i + cnt_i);
   assign ilv_w = start_i ^ cnt_i;

   generate
      if (MAP_SEL == MAP_STRAP) begin : g_strap
         assign low_o = (order_i == ORD_INTERLEAVE) ? ilv_w : lin_w;
      end else if (MAP_SEL == MAP_LINEAR) begin : g_linear
         assign low_o = lin_w;
      end else if (MAP_SEL == MAP_INTERLEAVE) begin : g_ilv
         assign low_o = ilv_w;
      end else begin : g_bad_sel
         $error("burst_seq_map: unknown MAP_SEL");
         assign low_o = '0;
      end
   endgenerate
endmodule

// File: rtl/burst_seq.sv
module burst_seq
   import burst_seq_pkg::*;
#(
   parameter int ADDR_W  = 18,
   parameter int CNT_W   = 2,
   parameter int MAP_SEL = MAP_STRAP,
   localparam int HI_W   = ADDR_W - CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              adv_n_i,
   input  logic              order_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CNT_W-1:0]  pos_o
);
   generate
      if (CNT_W < 1 || ADDR_W <= CNT_W) begin : g_bad_w
         $error("burst_seq: need 1 <= CNT_W < ADDR_W");
      end
   endgenerate

   logic [HI_W-1:0]  base_w;
   logic [CNT_W-1:0] start_w;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] low_w;
   order_e           ord_w;
   logic             eff_ilv;

   assign ord_w = order_e'(order_i);
   assign eff_ilv = (MAP_SEL == MAP_INTERLEAVE) ? 1'b1 :
                    (MAP_SEL == MAP_LINEAR)     ? 1'b0 : order_i;

   burst_seq_areg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_areg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .addr_i  (addr_i),
      .base_o  (base_w),
      .start_o (start_w)
   );

   burst_seq_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load_i),
      .adv_n_i (adv_n_i),
      .cnt_o   (cnt_w)
   );

   burst_seq_map #(.CNT_W(CNT_W), .MAP_SEL(MAP_SEL)) u_map (
      .order_i (ord_w),
      .start_i (start_w),
      .cnt_i   (cnt_w),
      .low_o   (low_w)
   );

   assign addr_o = {base_w, low_w};
   assign pos_o  = cnt_w;

   AST_ORDER_STATIC: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(order_i)); // R5
   AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i && !eff_ilv) |=>
      (addr_o[CNT_W-1:0] == CNT_W'($past(addr_o[CNT_W-1:0]) + 1'b1))); // R5
   AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_n_i && eff_ilv) |=>
      ((addr_o[CNT_W-1:0] ^ $past(addr_o[CNT_W-1:0])) == (pos_o ^ $past(pos_o)))); // R6
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (addr_o == '0 && pos_o == '0)); // R1
endmodule

// File: tb/sim_burst_seq.sv
`timescale 1ns/1ps
module sim_burst_seq;
   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          adv_n_i = 1'b1;
   logic          order_i = 1'b1;
   logic [AW-1:0] addr_o;
   logic [1:0]    pos_o;

   always #2.5 clk = ~clk;

   burst_seq u0 (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .addr_i(addr_i),
      .adv_n_i(adv_n_i), .order_i(order_i), .addr_o(addr_o), .pos_o(pos_o)
   );

   typedef struct {
      logic [AW-1:0] addr;
      logic [1:0]    pos;
      string         tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   // reference model
   logic [AW-3:0] m_base;
   logic [1:0]    m_start, m_cnt;

   function automatic logic [1:0] low_of(logic [1:0] s, logic [1:0] c, logic ilv);
      return ilv ? (s ^ c) : 2'(s + c);
   endfunction

   task automatic step(input logic ld, input logic [AW-1:0] a, input logic adv_n);
      exp_t  e;
      string tg;
      @(negedge clk);
      load_i = ld; addr_i = a; adv_n_i = adv_n;
      if (ld) begin
         tg = (m_cnt != 2'd0) ? "R8" : "R2";
         m_base = a[AW-1:2]; m_start = a[1:0]; m_cnt = 2'd0;
      end else if (!adv_n) begin
         m_cnt = 2'(m_cnt + 1);
         tg = (m_cnt == 2'd0) ? "R9" : "R3";
      end else begin
         tg = "R4";
      end
      e.addr = {m_base, low_of(m_start, m_cnt, order_i)};
      e.pos  = m_cnt;
      e.tag  = tg;
      q.push_back(e);
   endtask

   task automatic do_reset(input logic ord);
      @(negedge clk);
      rst_n = 1'b0; load_i = 1'b0; adv_n_i = 1'b1; order_i = ord;
      repeat (3) @(negedge clk);
      n_chk++;
      if (addr_o !== '0 || pos_o !== 2'd0) begin
         n_bad++;
         $display("FAIL R1: addr=%h pos=%0d expected addr=0 pos=0", addr_o, pos_o);
      end
      rst_n = 1'b1;
      m_base = '0; m_start = '0; m_cnt = '0;
   endtask

   // monitor
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t  e;
         string ltag;
         e = q.pop_front();
         ltag = order_i ? "R6" : "R5";
         n_chk += 3;
         if (addr_o[AW-1:2] !== e.addr[AW-1:2]) begin
            n_bad++;
            $display("FAIL R7 (%s): upper=%h expected %h", e.tag, addr_o[AW-1:2], e.addr[AW-1:2]);
         end
         if (addr_o[1:0] !== e.addr[1:0]) begin
            n_bad++;
            $display("FAIL %s (%s): low=%0d expected %0d", ltag, e.tag, addr_o[1:0], e.addr[1:0]);
         end
         if (pos_o !== e.pos) begin
            n_bad++;
            $display("FAIL %s: pos=%0d expected %0d", e.tag, pos_o, e.pos);
         end
      end
   end

   initial begin
      for (int mode = 0; mode < 2; mode++) begin
         do_reset(mode[0]);
         step(1'b0, '0, 1'b0);            // R3 advance straight from reset
         for (int s = 0; s < 4; s++) begin
            logic [AW-1:0] a;
            a = {16'(16'h5A3C + s * 16'h1111 + mode * 16'h0F0F), 2'(s)};
            step(1'b1, a, 1'b1);          // R2 load
            for (int k = 0; k < 4; k++) step(1'b0, ~a, 1'b0); // R5/R6 sequence, R9 wrap
            step(1'b0, ~a, 1'b1);         // R4 hold
            step(1'b0, ~a, 1'b1);         // R4 hold
            step(1'b0, ~a, 1'b0);
            step(1'b0, ~a, 1'b0);
            step(1'b1, {~a[AW-1:2], 2'(s + 1)}, 1'b0); // R8 reload mid-burst with advance
            step(1'b0, '0, 1'b0);
            step(1'b1, a, 1'b0);          // R8 reload again
         end
         step(1'b0, '0, 1'b1);
         wait (q.size() == 0);
         @(negedge clk);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule